// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches a bank of already-synchronized GPIO inputs and raises a per-pin pending flag when a configured condition is seen. By default a pin flags every change of its input level, in either direction. A per-pin extended-mode switch replaces this with one of four narrower conditions: rising edge, falling edge, high level or low level. Edge or level, and the polarity, are chosen per pin.

A simple word-addressed register port configures the block. Each configuration mask has a write-one-to-set address, a write-one-to-clear address and a readback address. The pending flags are collected in a status word that clears when read. A single interrupt line summarises all enabled pending pins. Edges are found by comparing each pin with its sample from the previous cycle. Pending flags collect whether or not a pin is enabled, so software can poll masked pins.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset the enable, extended-mode, level-select, polarity and status words all read 0, and `irq_o` is low.
- R2: Writing to address 0x0 sets, and writing to address 0x1 clears, the enable bits at the positions where the write data is 1. Address 0x2 reads the enable mask.
- R3: Writing to address 0x4 sets, and writing to address 0x5 clears, per-pin extended-mode bits at the 1 positions of the write data. Address 0x6 reads the mode mask.
- R4: Writing to address 0x7 clears (selecting edge), and writing to address 0x8 sets (selecting level), per-pin trigger-type bits. Address 0x9 reads them, with 1 meaning level.
- R5: Writing to address 0xA clears (selecting falling/low), and writing to address 0xB sets (selecting rising/high), per-pin polarity bits. Address 0xC reads them, with 1 meaning rising or high.
- R6: A pin whose extended-mode bit is 0 sets its status bit on both rising and falling transitions. The bit is visible from the clock edge that first samples the new level. A steady pin sets nothing.
- R7: With extended mode on and type edge, a pin sets its status only on the selected transition: rising when polarity is 1, falling when it is 0.
- R8: With extended mode on and type level, the status bit is set on every cycle that the pin is at the active level (high when polarity is 1, low when 0). A read that clears it therefore sees it set again while the level persists.
- R9: A read of address 0x3 returns the status word and clears it at the same clock edge. A condition detected at that edge stays pending.
- R10: `irq_o` is high exactly while some status bit is set whose enable bit is also set. Status bits update regardless of the enable mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Word address |
| wdata_i | input | N_PINS | Write data (bit n acts on pin n) |
| rdata_o | output | N_PINS | Read data, combinational, 0 when not reading |
| pin_i | input | N_PINS | Synchronized pin levels |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench drives a status read in the same cycle as a new pin edge. A design that lets the clear win over the new condition would lose that edge, and the next read would show 0 instead of the pin's bit. It holds a level-mode pin active across two reads, and then drops the level just before a third read. A design that ignores the level after a clear would read 0 too early, and one that keeps latching the condition would fail to read 0 at the end. It also checks each extended pin against transitions in the wrong direction. It raises a pending bit on a masked pin, then removes the enable of a flagged pin. An interrupt line gated wrongly, or status gated by the mask, shows up as a wrong `irq_o` or a missing status bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_IEN_SET   = 4'h0,
    A_IEN_CLR   = 4'h1,
    A_IMASK     = 4'h2,
    A_STATUS    = 4'h3,
    A_MODE_SET  = 4'h4,
    A_MODE_CLR  = 4'h5,
    A_MODE      = 4'h6,
    A_SEL_EDGE  = 4'h7,
    A_SEL_LEVEL = 4'h8,
    A_LEVEL     = 4'h9,
    A_SEL_FALL  = 4'hA,
    A_SEL_RISE  = 4'hB,
    A_POL       = 4'hC
  } reg_addr_e;
endpackage

// File: rtl/setclr_reg.sv
module setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (set_i) q_o <= q_o | data_i;
    else if (clr_i) q_o <= q_o & ~data_i;
  end
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic mode_i,
  input  logic level_i,
  input  logic pol_i,
  output logic prev_o,
  output logic hit_o
);
  logic rise, fall, ext_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= 1'b0;
    else         prev_o <= pin_i;
  end

  assign rise = pin_i & ~prev_o;
  assign fall = ~pin_i & prev_o;

  always_comb begin
    if (level_i) ext_hit = pol_i ? pin_i : ~pin_i;
    else         ext_hit = pol_i ? rise : fall;
  end

  assign hit_o = mode_i ? ext_hit : (rise | fall);
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] hit_i,
  input  logic         clr_i,
  output logic [W-1:0] status_o
);
  // new hits win over the clear of the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else         status_o <= (clr_i ? '0 : status_o) | hit_i;
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic              irq_o
);
  logic wr_en, rd_en, rd_status;
  logic [N_PINS-1:0] mask_q, mode_q, level_q, pol_q, status_q, prev_q, hit;

  assign wr_en     = req_i & we_i;
  assign rd_en     = req_i & ~we_i;
  assign rd_status = rd_en && (addr_i == A_STATUS);

  setclr_reg #(.W(N_PINS)) u_mask (
    .clk_i, .rst_ni,
    .set_i (wr_en && addr_i == A_IEN_SET),
    .clr_i (wr_en && addr_i == A_IEN_CLR),
    .data_i(wdata_i), .q_o(mask_q));

  setclr_reg #(.W(N_PINS)) u_mode (
    .clk_i, .rst_ni,
    .set_i (wr_en && addr_i == A_MODE_SET),
    .clr_i (wr_en && addr_i == A_MODE_CLR),
    .data_i(wdata_i), .q_o(mode_q));

  setclr_reg #(.W(N_PINS)) u_level (
    .clk_i, .rst_ni,
    .set_i (wr_en && addr_i == A_SEL_LEVEL),
    .clr_i (wr_en && addr_i == A_SEL_EDGE),
    .data_i(wdata_i), .q_o(level_q));

  setclr_reg #(.W(N_PINS)) u_pol (
    .clk_i, .rst_ni,
    .set_i (wr_en && addr_i == A_SEL_RISE),
    .clr_i (wr_en && addr_i == A_SEL_FALL),
    .data_i(wdata_i), .q_o(pol_q));

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    gpio_irq_pin u_pin (
      .clk_i, .rst_ni,
      .pin_i  (pin_i[i]),
      .mode_i (mode_q[i]),
      .level_i(level_q[i]),
      .pol_i  (pol_q[i]),
      .prev_o (prev_q[i]),
      .hit_o  (hit[i]));
  end

  gpio_irq_status #(.W(N_PINS)) u_status (
    .clk_i, .rst_ni,
    .hit_i   (hit),
    .clr_i   (rd_status),
    .status_o(status_q));

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      case (addr_i)
        A_IMASK:  rdata_o = mask_q;
        A_STATUS: rdata_o = status_q;
        A_MODE:   rdata_o = mode_q;
        A_LEVEL:  rdata_o = level_q;
        A_POL:    rdata_o = pol_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_o = |(status_q & mask_q);
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int N = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         req_i,
  input logic         we_i,
  input logic [3:0]   addr_i,
  input logic [N-1:0] wdata_i,
  input logic [N-1:0] pin_i,
  input logic         irq_o,
  input logic [N-1:0] mask_q,
  input logic [N-1:0] mode_q,
  input logic [N-1:0] level_q,
  input logic [N-1:0] pol_q,
  input logic [N-1:0] status_q,
  input logic [N-1:0] prev_q,
  input logic [N-1:0] hit,
  input logic         rd_status
);
  logic [N-1:0] any_edge, act_level;
  assign any_edge  = ~mode_q & (pin_i ^ prev_q);
  assign act_level = mode_q & level_q & ~(pin_i ^ pol_q);

  // R2
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 4'h0) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

  // R6
  any_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_edge != '0) |=> ((status_q & $past(any_edge)) == $past(any_edge)));

  // R8
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_level != '0) |=> ((status_q & $past(act_level)) == $past(act_level)));

  // R9
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_status && hit == '0) |=> (status_q == '0));

  // R10
  no_mask_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.N(N_PINS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .pin_i    (pin_i),
  .irq_o    (irq_o),
  .mask_q   (mask_q),
  .mode_q   (mode_q),
  .level_q  (level_q),
  .pol_q    (pol_q),
  .status_q (status_q),
  .prev_q   (prev_q),
  .hit      (hit),
  .rd_status(rd_status)
);

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n, req, we;
  logic [3:0] addr;
  logic [N-1:0] wdata, pins;
  logic [N-1:0] rdata;
  logic irq;

  typedef struct {
    bit           is_irq;
    logic [N-1:0] exp;
    string        tag;
  } item_t;

  item_t sb_q[$];
  bit mon_go = 1'b0;
  bit done = 1'b0;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_detect #(.N_PINS(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .irq_o(irq));

  // monitor: samples 2 time units after the falling edge
  initial forever begin
    @(negedge clk);
    #2;
    if (mon_go && sb_q.size() > 0) begin
      item_t it;
      logic [N-1:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {{(N-1){1'b0}}, irq} : rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: got %h exp %h", it.tag, act, it.exp);
      end
      mon_go = 1'b0;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_p(input logic [3:0] a, input logic [N-1:0] e, input string tag,
                      input bit chg, input logic [N-1:0] pv);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    if (chg) pins = pv;
    sb_q.push_back('{1'b0, e, tag});
    mon_go = 1'b1;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [N-1:0] e, input string tag);
    rd_p(a, e, tag, 1'b0, '0);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    sb_q.push_back('{1'b1, {{(N-1){1'b0}}, e}, tag});
    mon_go = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic set_pins(input logic [N-1:0] v);
    @(negedge clk);
    pins = v;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0; pins = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(4'h2, '0, "R1 imask");
    rd(4'h3, '0, "R1 status");
    rd(4'h6, '0, "R1 mode");
    rd(4'h9, '0, "R1 level");
    rd(4'hC, '0, "R1 pol");
    chk_irq(1'b0, "R1 irq");

    // R2 enable set/clear
    wr(4'h0, 32'h0000_00FF);
    wr(4'h1, 32'h0000_000F);
    rd(4'h2, 32'h0000_00F0, "R2 imask");

    // R6 default any-edge, R10 masked pin still flags
    set_pins(32'h1);
    chk_irq(1'b0, "R10 masked pin no irq");
    rd(4'h3, 32'h1, "R6 rise");
    rd(4'h3, '0, "R9 cleared by read");
    set_pins(32'h0);
    rd(4'h3, 32'h1, "R6 fall");
    rd(4'h3, '0, "R6 steady");

    // R10 enabled pin drives irq
    set_pins(32'h10);
    chk_irq(1'b1, "R10 irq on");
    rd(4'h3, 32'h10, "R10 status");
    chk_irq(1'b0, "R10 irq off after clear");
    set_pins(32'h0);
    rd(4'h3, 32'h10, "R6 fall pin4");

    // R5, R4, R3 configuration
    wr(4'hB, 32'h0007_0000);
    wr(4'hA, 32'h0002_0000);
    rd(4'hC, 32'h0005_0000, "R5 pol");
    wr(4'h8, 32'h000C_0000);
    wr(4'h7, 32'h0008_0000);
    rd(4'h9, 32'h0004_0000, "R4 level");
    wr(4'h4, 32'h000F_0000);
    wr(4'h5, 32'h0008_0000);
    rd(4'h6, 32'h0007_0000, "R3 mode");
    rd(4'h3, '0, "R8 inactive level");

    // R7 single-direction edges: 16 rising, 17 falling
    set_pins(32'h0003_0000);
    rd(4'h3, 32'h0001_0000, "R7 rising only");
    set_pins(32'h0);
    rd(4'h3, 32'h0002_0000, "R7 falling only");

    // R8 high level on pin 18
    set_pins(32'h0004_0000);
    rd(4'h3, 32'h0004_0000, "R8 high level");
    rd(4'h3, 32'h0004_0000, "R8 reassert");
    set_pins(32'h0);
    rd(4'h3, 32'h0004_0000, "R8 last pending");
    rd(4'h3, '0, "R8 level gone");

    // R8 low level on pin 17
    wr(4'h8, 32'h0002_0000);
    @(negedge clk);
    rd(4'h3, 32'h0002_0000, "R8 low level");
    set_pins(32'h0002_0000);
    rd(4'h3, 32'h0002_0000, "R8 low last pending");
    rd(4'h3, '0, "R8 low gone");

    // R9 edge in the same cycle as the clearing read
    rd_p(4'h3, '0, "R9 read during edge", 1'b1, 32'h0012_0000);
    rd(4'h3, 32'h0010_0000, "R9 edge kept");
    rd(4'h3, '0, "R9 then clear");

    // R10 removing the enable drops irq, status stays
    set_pins(32'h0012_0020);
    chk_irq(1'b1, "R10 pin5 irq");
    wr(4'h1, 32'h0000_0020);
    chk_irq(1'b0, "R10 disabled");
    rd(4'h2, 32'h0000_00D0, "R2 imask after clear");
    rd(4'h3, 32'h0000_0020, "R10 status kept");

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule